// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

This block is an 8-bit full-duplex synchronous serial port. In each transfer it shifts a byte out, most significant bit first, and shifts a byte in at the same time. A 4-bit mode input makes the port either the SPI clock master or an SPI slave. As master, the serial clock comes from a fixed divider on the system clock or from pulses on a timer input. As slave, the external clock drives the transfer, and an active-low select input can be used to gate it.

Software reaches the port through a simple bus. A write to the data register loads the transmit shift register, and as master it also starts a transfer. A finished transfer copies the received byte into the data register and sets a full flag, which a read clears. Two sticky flags report errors: a write that arrives during a transfer, and a byte that completes while the previous byte is still unread. A clear strobe resets both sticky flags.

Mode codes on `cfg_mode`: 0 = master, system clock / 4; 1 = master / 16; 2 = master / 64; 3 = master clocked by the timer input; 4 = slave with select; 5 = slave with the select ignored; 6 to 15 = port off.

Top module: `sync_serial_port`

## Requirements
- R1: Master operation is as follows. A write while idle starts a transfer that clocks out 8 bits and samples 8 bits. After 17 half-periods from the write edge, `busy` is low, `buf_full` is high and `rd_data` holds the sampled byte, with the first sampled bit as the MSB.
- R2: As master, `sck_o` equals `cfg_cpol` while idle. During half-period slot k (0..16) of a transfer it equals `cfg_cpol` XOR (k mod 2).
- R3: The data-out line starts with bit 7 of the byte. With `cfg_cpha`=0 it moves to the next bit on each trailing edge. With `cfg_cpha`=1 it moves to the next bit on each leading edge from the second one onward.
- R4: The master samples `sdi_i` at the end of half-period slots first+2i (i = 0..7). Here first = 2 when `cfg_cpha` and `cfg_smp` are both 1, and first = `cfg_cpha` XOR `cfg_smp` otherwise.
- R5: In modes 0, 1 and 2 one half-period lasts 2, 8 and 32 clock cycles.
- R6: In mode 3 each clock cycle with `tmr_tick` high counts as one half-period. The transfer ends on the 17th such pulse.
- R7: As slave (mode 4 with `ss_n_i` low, or mode 5 whatever the level of `ss_n_i`), the port samples on the leading `sck_i` edges when `cfg_cpha`=0 and on the trailing edges when `cfg_cpha`=1. It drives its loaded byte on `sdo_o` and completes after 16 edges.
- R8: In mode 4, a high `ss_n_i` clears the bit counter, drives `busy` low and `sdo_oe` low. A later byte is then received whole.
- R9: A `rd_en` pulse clears `buf_full`.
- R10: A write while `busy` is high sets `wcol` and is ignored. The transfer in progress still ends with its own last bit on `sdo_o`.
- R11: A transfer that completes while `buf_full` is high and `rd_en` is low sets `rov` and leaves `rd_data` unchanged.
- R12: After a master transfer, `sdo_o` holds bit 0 of the byte that was sent.
- R13: In modes 6 to 15 a write starts no transfer. `busy` stays low, `buf_full` stays low and `sck_o` equals `cfg_cpol`.
- R14: `flags_clr` clears `wcol` and `rov`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 4 | Mode and clock source code |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Clock edge select for data change and sampling |
| cfg_smp | input | 1 | Master sample point: 0 middle, 1 end of bit time |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe, clears the full flag |
| rd_data | output | 8 | Last received byte |
| flags_clr | input | 1 | Clears the collision and overflow flags |
| buf_full | output | 1 | Received byte not yet read |
| wcol | output | 1 | Sticky write-collision flag |
| rov | output | 1 | Sticky receive-overflow flag |
| busy | output | 1 | Transfer in progress |
| tmr_tick | input | 1 | Timer pulse used as the half-period source in mode 3 |
| sck_o | output | 1 | Serial clock driven as master |
| sck_i | input | 1 | Serial clock received as slave |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data-out line |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
As master, the clock and data-out lines take new values on the first edge of each half-period slot. The write edge starts slot 0, and each further slot begins H cycles after the previous one. The bench checks every slot at the falling clock edge inside it. It changes `sdi_i` at the same point, so that every sample edge reads a known slot value. The received byte and the flags become valid on edge 17H after the write. The bench checks that `busy` is still high one cycle before that edge and that the result is in place right after it. On the slave side each line passes a two-stage synchronizer and an edge detector, so the slave reacts three cycles after an input edge. The bench holds every input level for 8 cycles and reads `sdo_o` just before the next edge it drives.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam logic [3:0] M_DIV4  = 4'd0;
  localparam logic [3:0] M_DIV16 = 4'd1;
  localparam logic [3:0] M_DIV64 = 4'd2;
  localparam logic [3:0] M_TMR   = 4'd3;
  localparam logic [3:0] S_SEL   = 4'd4;
  localparam logic [3:0] S_FREE  = 4'd5;

  // clock cycles in one half-period of the master serial clock
  function automatic int half_cycles(logic [3:0] m);
    case (m)
      M_DIV16: return 8;
      M_DIV64: return 32;
      default: return 2;
    endcase
  endfunction

  function automatic logic mode_master(logic [3:0] m);
    return m <= M_TMR;
  endfunction

  function automatic logic mode_slave(logic [3:0] m);
    return (m == S_SEL) || (m == S_FREE);
  endfunction

  // is edge index k a sampling event
  function automatic logic sample_edge(int k, logic cpha, logic smp, int last);
    logic odd;
    odd = cpha ^ smp;
    if ((k % 2 == 1) != odd) return 1'b0;
    if (cpha && smp) return k >= 2;
    return k < last;
  endfunction

  // is edge index k a data-out change event
  function automatic logic shift_edge(int k, logic cpha, int last);
    return ((k % 2 == 0) == cpha) && (k >= 1) && (k <= last - 2);
  endfunction
endpackage

// File: rtl/ssp_tick_gen.sv
module ssp_tick_gen
  import ssp_pkg::*;
#(
  parameter int MAX_HALF = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] mode,
  input  logic       tmr_tick,
  output logic       tick
);
  localparam int DIV_W = $clog2(MAX_HALF);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             use_tmr;

  always_comb begin
    use_tmr = (mode == M_TMR);
    lim     = DIV_W'(half_cycles(mode) - 1);
    tick    = run && (use_tmr ? tmr_tick : (cnt == lim));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (!run || tick || use_tmr) cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    run && !use_tmr && tick |=> !tick); // R5
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              smp,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              tick,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              ss_n_i,
  output logic              run,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              sdo_oe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data
);
  localparam int LAST  = 2 * DATA_W;
  localparam int CNT_W = $clog2(LAST + 1);

  logic master, slave, deselect, start, ev, sample_now, shift_now, in_bit;
  logic sck_s, sdi_s, ss_s, sck_prev, sck_r;
  logic [SYNC_N-1:0] sck_sync, sdi_sync, ss_sync;
  logic [CNT_W-1:0]  edge_cnt;
  logic [DATA_W-1:0] tx_q, rx_q;

  // input synchronizers for slave operation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync <= '0;
      sdi_sync <= '0;
      ss_sync  <= '1;
      sck_prev <= 1'b0;
    end else begin
      sck_sync <= {sck_sync[SYNC_N-2:0], sck_i};
      sdi_sync <= {sdi_sync[SYNC_N-2:0], sdi_i};
      ss_sync  <= {ss_sync[SYNC_N-2:0], ss_n_i};
      sck_prev <= sck_s;
    end
  end

  always_comb begin
    sck_s      = sck_sync[SYNC_N-1];
    sdi_s      = sdi_sync[SYNC_N-1];
    ss_s       = ss_sync[SYNC_N-1];
    master     = mode_master(mode);
    slave      = mode_slave(mode);
    deselect   = (mode == S_SEL) && ss_s;
    start      = load && master;
    ev         = master ? (run && tick) : (slave && !deselect && (sck_s != sck_prev));
    sample_now = ev && sample_edge(int'(edge_cnt), cpha, master ? smp : 1'b0, LAST);
    shift_now  = ev && shift_edge(int'(edge_cnt), cpha, LAST);
    done       = ev && (master ? (edge_cnt == CNT_W'(LAST)) : (edge_cnt == CNT_W'(LAST - 1)));
    in_bit     = master ? sdi_i : sdi_s;
    rx_data    = sample_now ? {rx_q[DATA_W-2:0], in_bit} : rx_q;
    busy       = run || (edge_cnt != '0);
    sck_o      = run ? sck_r : cpol;
    sdo_o      = tx_q[DATA_W-1];
    sdo_oe     = master || (slave && !deselect);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      edge_cnt <= '0;
      sck_r    <= 1'b0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      if (!master || done) run <= 1'b0;
      else if (start)      run <= 1'b1;

      if (!(master || slave) || deselect || done || start) edge_cnt <= '0;
      else if (ev)                                         edge_cnt <= edge_cnt + 1'b1;

      if (start)                                             sck_r <= cpol;
      else if (master && ev && (edge_cnt < CNT_W'(LAST)))    sck_r <= ~sck_r;

      if (load)           tx_q <= load_data;
      else if (shift_now) tx_q <= {tx_q[DATA_W-2:0], 1'b0};

      rx_q <= rx_data;
    end
  end

  AST_SCK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    master && run && tick && (edge_cnt < CNT_W'(LAST)) |=> sck_o != $past(sck_o)); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R1
  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    deselect |=> !busy); // R8
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !master && !slave |=> !busy); // R13
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DATA_W   = 8,
  parameter int SYNC_N   = 2,
  parameter int MAX_HALF = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cfg_mode,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_smp,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              flags_clr,
  output logic              buf_full,
  output logic              wcol,
  output logic              rov,
  output logic              busy,
  input  logic              tmr_tick,
  output logic              sck_o,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe,
  input  logic              ss_n_i
);
  logic              run, tick, done, wr_ok, wr_hit;
  logic [DATA_W-1:0] rx_data, buf_q;

  assign wr_ok   = wr_en && !busy;
  assign wr_hit  = wr_en && busy;
  assign rd_data = buf_q;

  ssp_tick_gen #(.MAX_HALF(MAX_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(cfg_mode),
    .tmr_tick(tmr_tick), .tick(tick)
  );

  ssp_engine #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_eng (
    .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .cpol(cfg_cpol),
    .cpha(cfg_cpha), .smp(cfg_smp), .load(wr_ok), .load_data(wr_data),
    .tick(tick), .sck_i(sck_i), .sdi_i(sdi_i), .ss_n_i(ss_n_i),
    .run(run), .sck_o(sck_o), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .busy(busy), .done(done), .rx_data(rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      buf_full <= 1'b0;
      wcol     <= 1'b0;
      rov      <= 1'b0;
    end else begin
      if (done && (!buf_full || rd_en)) buf_q <= rx_data;

      if (done)       buf_full <= 1'b1;
      else if (rd_en) buf_full <= 1'b0;

      if (wr_hit)         wcol <= 1'b1;
      else if (flags_clr) wcol <= 1'b0;

      if (done && buf_full && !rd_en) rov <= 1'b1;
      else if (flags_clr)             rov <= 1'b0;
    end
  end

  AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && busy |=> wcol); // R10
  AST_ROV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && buf_full && !rd_en |=> rov && $stable(rd_data)); // R11
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !done |=> !buf_full); // R9
  AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> buf_full); // R1
endmodule

// File: tb/sim_sync_serial_port.sv
module sim_sync_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int HS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cfg_mode = 4'd0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_smp = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, flags_clr = 1'b0, tmr_tick = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic sck_i = 1'b0, sdi_i = 1'b0, ss_n_i = 1'b1;
  logic [7:0] rd_data;
  logic buf_full, wcol, rov, busy, sck_o, sdo_o, sdo_oe;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_smp(cfg_smp), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .flags_clr(flags_clr), .buf_full(buf_full),
    .wcol(wcol), .rov(rov), .busy(busy), .tmr_tick(tmr_tick), .sck_o(sck_o),
    .sck_i(sck_i), .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .ss_n_i(ss_n_i)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int hp(input logic [3:0] m);
    if (m == 4'd1) return 8;
    if (m == 4'd2) return 32;
    return 2;
  endfunction

  function automatic logic [7:0] exp_rx(input logic [16:0] pat, input logic ph, input logic sp);
    int first;
    logic [7:0] r;
    first = (ph && sp) ? 2 : ((ph != sp) ? 1 : 0);
    for (int i = 0; i < 8; i++) r[7-i] = pat[first + 2*i];
    return r;
  endfunction

  function automatic logic exp_sdo(input logic [7:0] d, input int k, input logic ph);
    int n;
    if (!ph) n = k / 2;
    else     n = (k == 0) ? 0 : (k - 1) / 2;
    if (n > 7) n = 7;
    return d[7-n];
  endfunction

  task automatic do_read();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic master_xfer(input logic [3:0] m, input logic pol, input logic ph,
                             input logic sp, input logic [7:0] d, input logic [16:0] pat);
    int h, sck_bad, sdo_bad;
    @(negedge clk);
    cfg_mode = m; cfg_cpol = pol; cfg_cpha = ph; cfg_smp = sp; sdi_i = pat[0];
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    h = hp(m); sck_bad = 0; sdo_bad = 0;
    for (int k = 0; k <= 16; k++) begin
      if (k > 0) sdi_i = pat[k];
      if (sck_o !== (pol ^ (k % 2 == 1))) sck_bad++;
      if (sdo_o !== exp_sdo(d, k, ph)) sdo_bad++;
      if (k < 16) repeat (h) @(negedge clk);
    end
    repeat (h - 1) @(negedge clk);
    chk(busy === 1'b1, "R5 busy before last half-period", 32'(busy), 1);
    @(negedge clk);
    chk(sck_bad == 0, "R2 sck slots", sck_bad, 0);
    chk(sdo_bad == 0, "R3 sdo slots", sdo_bad, 0);
    chk(busy === 1'b0 && buf_full === 1'b1, "R1 done flags", {busy, buf_full}, 2'b01);
    chk(rd_data === exp_rx(pat, ph, sp), sp ? "R4 rx byte" : "R1 rx byte", rd_data, exp_rx(pat, ph, sp));
    chk(sdo_o === d[0], "R12 sdo idle", sdo_o, d[0]);
    chk(sck_o === pol, "R2 sck idle", sck_o, pol);
    do_read();
    chk(buf_full === 1'b0, "R9 read clears", buf_full, 0);
  endtask

  task automatic slave_xfer(input logic [3:0] m, input logic pol, input logic ph,
                            input logic [7:0] tx, input logic [7:0] rx, input bit use_ss);
    logic [7:0] cap;
    @(negedge clk);
    cfg_mode = 4'hF; sck_i = pol; ss_n_i = 1'b1; sdi_i = 1'b0;
    repeat (4) @(negedge clk);
    cfg_mode = m; cfg_cpol = pol; cfg_cpha = ph;
    @(negedge clk);
    wr_en = 1'b1; wr_data = tx;
    @(negedge clk);
    wr_en = 1'b0;
    if (use_ss) ss_n_i = 1'b0;
    if (!ph) sdi_i = rx[7];
    cap = 8'h00;
    repeat (HS) @(negedge clk);
    chk(sdo_oe === 1'b1, "R7 slave drives sdo", sdo_oe, 1);
    for (int i = 0; i < 8; i++) begin
      if (!ph) begin
        cap[7-i] = sdo_o;
        sck_i = ~pol;
        repeat (HS) @(negedge clk);
        sck_i = pol;
        if (i < 7) sdi_i = rx[6-i];
        repeat (HS) @(negedge clk);
      end else begin
        sck_i = ~pol; sdi_i = rx[7-i];
        repeat (HS) @(negedge clk);
        cap[7-i] = sdo_o;
        sck_i = pol;
        repeat (HS) @(negedge clk);
      end
    end
    chk(buf_full === 1'b1 && busy === 1'b0, "R7 slave done", {buf_full, busy}, 2'b10);
    chk(rd_data === rx, "R7 slave rx", rd_data, rx);
    chk(cap === tx, "R7 slave tx", cap, tx);
    do_read();
    ss_n_i = 1'b1;
  endtask

  task automatic run_const(input logic [7:0] d, input logic v);
    @(negedge clk);
    sdi_i = v; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 0 && buf_full === 0 && wcol === 0 && rov === 0, "R1 reset state",
        {busy, buf_full, wcol, rov}, 0);
    chk(sck_o === 1'b0, "R2 reset sck", sck_o, 0);

    // all four clock modes with both sample points, system /4
    for (int c = 0; c < 8; c++)
      master_xfer(4'd0, c[0], c[1], c[2], 8'hA5 ^ 8'(c * 17), 17'h1B3C5 ^ 17'(c * 977));
    master_xfer(4'd1, 1'b0, 1'b1, 1'b0, 8'h3C, 17'h0F0F0); // R5
    master_xfer(4'd2, 1'b1, 1'b0, 1'b1, 8'hC3, 17'h15555); // R5

    // timer-driven clock
    @(negedge clk);
    cfg_mode = 4'd3; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_smp = 1'b0; sdi_i = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h81;
    @(negedge clk);
    wr_en = 1'b0;
    for (int p = 0; p < 17; p++) begin
      if (p == 16) chk(busy === 1'b1, "R6 busy after 16 pulses", busy, 1);
      tmr_tick = 1'b1;
      @(negedge clk);
      tmr_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
    chk(busy === 1'b0 && rd_data === 8'hFF, "R6 timer done", {busy, rd_data}, 9'h0FF);
    do_read();

    // write collision, then clear
    @(negedge clk);
    cfg_mode = 4'd0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    sdi_i = 1'b0; wr_en = 1'b1; wr_data = 8'h3C;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0;
    chk(wcol === 1'b1, "R10 wcol set", wcol, 1);
    repeat (40) @(negedge clk);
    chk(sdo_o === 1'b0 && rd_data === 8'h00, "R10 write ignored", {sdo_o, rd_data}, 0);
    flags_clr = 1'b1;
    @(negedge clk);
    flags_clr = 1'b0;
    chk(wcol === 1'b0, "R14 wcol cleared", wcol, 0);
    do_read();

    // receive overflow
    run_const(8'h11, 1'b1);
    chk(rd_data === 8'hFF && rov === 1'b0, "R1 first byte", {rov, rd_data}, 9'h0FF);
    run_const(8'h22, 1'b0);
    chk(rov === 1'b1 && rd_data === 8'hFF && buf_full === 1'b1, "R11 overflow keeps old",
        {rov, buf_full, rd_data}, 10'h3FF);
    flags_clr = 1'b1;
    @(negedge clk);
    flags_clr = 1'b0;
    chk(rov === 1'b0, "R14 rov cleared", rov, 0);
    do_read();

    // reserved mode
    @(negedge clk);
    cfg_mode = 4'hA; cfg_cpol = 1'b1;
    run_const(8'h55, 1'b1);
    chk(busy === 0 && buf_full === 0 && sck_o === 1, "R13 port off", {busy, buf_full, sck_o}, 3'b001);

    // slave transfers
    slave_xfer(4'd4, 1'b0, 1'b0, 8'hB4, 8'h5A, 1'b1);
    slave_xfer(4'd4, 1'b1, 1'b1, 8'h2D, 8'hE7, 1'b1);
    slave_xfer(4'd5, 1'b0, 1'b1, 8'h96, 8'h3B, 1'b0);
    slave_xfer(4'd5, 1'b1, 1'b0, 8'h0F, 8'hC8, 1'b0);

    // deselect mid-byte
    @(negedge clk);
    cfg_mode = 4'hF; sck_i = 1'b0; ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    cfg_mode = 4'd4; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    wr_en = 1'b1; wr_data = 8'hA5;
    @(negedge clk);
    wr_en = 1'b0; ss_n_i = 1'b0;
    repeat (HS) @(negedge clk);
    for (int e = 0; e < 6; e++) begin
      sck_i = ~sck_i;
      repeat (HS) @(negedge clk);
    end
    chk(busy === 1'b1, "R8 mid-byte busy", busy, 1);
    ss_n_i = 1'b1;
    repeat (5) @(negedge clk);
    chk(busy === 1'b0 && sdo_oe === 1'b0, "R8 deselect", {busy, sdo_oe}, 0);
    slave_xfer(4'd4, 1'b0, 1'b0, 8'h71, 8'h9C, 1'b1); // R8 counter restarted

    // random master traffic
    for (int n = 0; n < 20; n++) begin
      logic [3:0] m;
      m = ($urandom % 5 == 0) ? 4'd2 : 4'($urandom % 2);
      master_xfer(m, 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 17'($urandom));
    end
    for (int n = 0; n < 4; n++)
      slave_xfer(4'd4 + 4'($urandom % 2), 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule